// File: doc/BRIEF.md
# Threshold and Range Compare Unit

This block sits at the output of a conversion engine and decides whether each finished result is kept. A compare setup (an enable, a range selector, a direction selector and two 12-bit compare values) is evaluated against the incoming result in the same cycle. When the result passes, the block latches it into its result register and raises a done flag. When it fails, the result is discarded and the earlier result and flag stay as they were.

The single-threshold form tests the result against the first compare value only. The direction selector picks between "below the value" and "at or above the value". The range form uses both compare values. Which one holds the larger value decides whether the test is for inside the window or for outside it. The direction selector also decides whether the bounds themselves count as passing. The compare values reach the block as one packed 32-bit word, with the first value in bits 11:0 and the second in bits 27:16.

The holding stage is a two-state machine. In `ST_EMPTY` the done flag is low. In `ST_FULL` it is high. The transitions are:
- `T_CAPTURE` (EMPTY to FULL): an accepted result arrives.
- `T_REFILL` (FULL to FULL): a further accepted result overwrites the stored one.
- `T_DRAIN` (FULL to EMPTY): a clear request arrives with no accepted result in the same cycle.
- `T_IDLE`: any state with nothing to do.

Top module: `thresh_cmp_unit`

## Requirements
- R1: The first compare value is taken from `cmp_word[11:0]` and the second from `cmp_word[27:16]`. Bits 15:12 and 31:28 have no effect on `accept`.
- R2: With `cmp_en` = 0, `accept` is 1 for every result value.
- R3: With `cmp_en` = 1, `range_en` = 0 and `gt_sel` = 0, `accept` is 1 exactly when the result is strictly less than the first compare value.
- R4: With `cmp_en` = 1, `range_en` = 0 and `gt_sel` = 1, `accept` is 1 exactly when the result is greater than or equal to the first compare value.
- R5: With `range_en` = 0, the second compare value has no effect on `accept`.
- R6: With `range_en` = 1, `gt_sel` = 1 and first value ≤ second value, `accept` is 1 exactly when first ≤ result ≤ second.
- R7: With `range_en` = 1, `gt_sel` = 0 and first value ≤ second value, `accept` is 1 exactly when first < result < second. This window is empty when the two values are equal.
- R8: With `range_en` = 1, `gt_sel` = 1 and first value > second value, `accept` is 1 exactly when result ≤ second or result ≥ first.
- R9: With `range_en` = 1, `gt_sel` = 0 and first value > second value, `accept` is 1 exactly when result < second or result > first.
- R10: A cycle with `res_valid` = 1 and `accept` = 1 loads `res_data` into `stored_data` and sets `done_flag`, both visible after that clock edge.
- R11: A cycle with `res_valid` = 1 and `accept` = 0 leaves `stored_data` and `done_flag` unchanged.
- R12: `flag_clr` = 1 clears `done_flag` at the next edge and leaves `stored_data` unchanged. When an accepted result arrives in the same cycle, the flag is set instead.
- R13: After reset, `done_flag` is 0 and `stored_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | A finished result is present this cycle |
| res_data | input | 12 | Finished result |
| cmp_word | input | 32 | Packed compare values: first in 11:0, second in 27:16 |
| cmp_en | input | 1 | Compare enable; 0 accepts everything |
| range_en | input | 1 | 1 uses both values as a window |
| gt_sel | input | 1 | Direction and bound-inclusion selector |
| flag_clr | input | 1 | Clear request for the done flag |
| accept | output | 1 | Combinational pass decision for `res_data` |
| stored_data | output | 12 | Last accepted result |
| done_flag | output | 1 | High while an accepted result is held |

## Verification
The hardest cases to reach are the bound cases of the range modes. These are the result equal to either compare value, and the degenerate window where both compare values are equal, where the exclusive window admits nothing and the inclusive one admits a single code. The stimulus reaches them by sweeping each compare setup over a set of values built around both compare values, one below, equal and one above each. The sweep mixes accepted and rejected results so that the held data is overwritten or kept. A clear request issued in the same cycle as an accepted result is staged on purpose, to exercise the priority of the flag set.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

    // Resolved compare behaviour, one code per distinct test
    typedef enum logic [2:0] {
        MD_PASS      = 3'd0,
        MD_BELOW     = 3'd1,
        MD_AT_ABOVE  = 3'd2,
        MD_IN_EXCL   = 3'd3,
        MD_IN_INCL   = 3'd4,
        MD_OUT_EXCL  = 3'd5,
        MD_OUT_INCL  = 3'd6
    } cmp_mode_e;

    // Holding stage states
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } hold_state_e;

endpackage

// File: rtl/tcu_mode_decode.sv
module tcu_mode_decode
    import tcu_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              cmp_en,
    input  logic              range_en,
    input  logic              gt_sel,
    input  logic [DATA_W-1:0] cv_lo_field,
    input  logic [DATA_W-1:0] cv_hi_field,
    output cmp_mode_e         mode
);

    // Window orientation: first value above second means outside test
    logic swapped;
    assign swapped = (cv_lo_field > cv_hi_field);

    always_comb begin
        mode = MD_PASS;
        unique case ({cmp_en, range_en, gt_sel})
            3'b000, 3'b001, 3'b010, 3'b011: mode = MD_PASS;
            3'b100: mode = MD_BELOW;
            3'b101: mode = MD_AT_ABOVE;
            3'b110: mode = swapped ? MD_OUT_EXCL : MD_IN_EXCL;
            3'b111: mode = swapped ? MD_OUT_INCL : MD_IN_INCL;
            default: mode = MD_PASS;
        endcase
    end

endmodule

// File: rtl/tcu_window_eval.sv
module tcu_window_eval
    import tcu_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  cmp_mode_e         mode,
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] cv_a,
    input  logic [DATA_W-1:0] cv_b,
    output logic              pass
);

    // Shared magnitude comparators
    logic a_lt, a_gt, b_lt, b_gt;
    assign a_lt = (sample < cv_a);
    assign a_gt = (sample > cv_a);
    assign b_lt = (sample < cv_b);
    assign b_gt = (sample > cv_b);

    always_comb begin
        pass = 1'b1;
        unique case (mode)
            MD_PASS:     pass = 1'b1;
            MD_BELOW:    pass = a_lt;
            MD_AT_ABOVE: pass = !a_lt;
            MD_IN_EXCL:  pass = a_gt && b_lt;
            MD_IN_INCL:  pass = !a_lt && !b_gt;
            MD_OUT_EXCL: pass = b_lt || a_gt;
            MD_OUT_INCL: pass = !b_gt || !a_lt;
            default:     pass = 1'b1;
        endcase
    end

endmodule

// File: rtl/tcu_result_hold.sv
module tcu_result_hold
    import tcu_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] din,
    input  logic              clr,
    output logic [DATA_W-1:0] dout,
    output logic              flag
);

    hold_state_e state_q, state_d;
    logic [DATA_W-1:0] data_q;

    // Next state: T_CAPTURE, T_REFILL, T_DRAIN, T_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (take) state_d = ST_FULL;
            ST_FULL: begin
                if (take)     state_d = ST_FULL;
                else if (clr) state_d = ST_EMPTY;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    data_q <= '0;
        else if (take) data_q <= din;
    end

    always_comb begin
        dout = data_q;
        flag = (state_q == ST_FULL);
    end

    p_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (flag && dout == $past(din)));

    p_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !clr) |=> ($stable(dout) && $stable(flag)));

    p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !take) |=> (!flag && $stable(dout)));

endmodule

// File: rtl/thresh_cmp_unit.sv
module thresh_cmp_unit
    import tcu_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int WORD_W  = 32,
    parameter int CV2_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic [WORD_W-1:0] cmp_word,
    input  logic              cmp_en,
    input  logic              range_en,
    input  logic              gt_sel,
    input  logic              flag_clr,
    output logic              accept,
    output logic [DATA_W-1:0] stored_data,
    output logic              done_flag
);

    localparam int CV1_LSB = 0;
    localparam int CV1_MSB = CV1_LSB + DATA_W - 1;
    localparam int CV2_MSB = CV2_LSB + DATA_W - 1;

    logic [DATA_W-1:0] cv1, cv2;
    assign cv1 = cmp_word[CV1_MSB:CV1_LSB];
    assign cv2 = cmp_word[CV2_MSB:CV2_LSB];

    cmp_mode_e mode;
    logic      take;

    tcu_mode_decode #(.DATA_W(DATA_W)) u_decode (
        .cmp_en      (cmp_en),
        .range_en    (range_en),
        .gt_sel      (gt_sel),
        .cv_lo_field (cv1),
        .cv_hi_field (cv2),
        .mode        (mode)
    );

    tcu_window_eval #(.DATA_W(DATA_W)) u_eval (
        .mode   (mode),
        .sample (res_data),
        .cv_a   (cv1),
        .cv_b   (cv2),
        .pass   (accept)
    );

    assign take = res_valid && accept;

    tcu_result_hold #(.DATA_W(DATA_W)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .take (take),
        .din  (res_data),
        .clr  (flag_clr),
        .dout (stored_data),
        .flag (done_flag)
    );

    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |-> accept);

    p_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && !range_en && !gt_sel) |-> (accept == (res_data < cv1)));

    p_inside_incl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && range_en && gt_sel && cv1 <= cv2 && res_data >= cv1 && res_data <= cv2) |-> accept);

    p_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !accept && !flag_clr) |=> ($stable(stored_data) && $stable(done_flag)));

endmodule

// File: tb/test_thresh_cmp_unit.sv
module test_thresh_cmp_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = '0;
    logic [31:0] cmp_word = '0;
    logic        cmp_en = 1'b0, range_en = 1'b0, gt_sel = 1'b0, flag_clr = 1'b0;
    logic        accept, done_flag;
    logic [11:0] stored_data;

    always #10 clk = ~clk;

    thresh_cmp_unit i_thresh_cmp_unit (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .cmp_word(cmp_word), .cmp_en(cmp_en), .range_en(range_en), .gt_sel(gt_sel),
        .flag_clr(flag_clr), .accept(accept), .stored_data(stored_data), .done_flag(done_flag)
    );

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    typedef struct { logic [11:0] d; logic f; string tag; } exp_t;
    exp_t sb[$];
    logic [11:0] m_data = '0;
    logic        m_flag = 1'b0;
    logic [11:0] c1 = '0, c2 = '0;

    task automatic check(bit ok, string tag, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit model_acc(bit en, bit rng, bit gt, int x, int a, int b);
        if (!en) return 1;
        if (!rng) return gt ? (x >= a) : (x < a);
        if (a <= b) return gt ? (x >= a && x <= b) : (x > a && x < b);
        return gt ? (x <= b || x >= a) : (x < b || x > a);
    endfunction

    task automatic set_cfg(bit en, bit rng, bit gt, int a, int b, logic [3:0] junk);
        @(negedge clk);
        cmp_en = en; range_en = rng; gt_sel = gt;
        c1 = a[11:0]; c2 = b[11:0];
        cmp_word = {junk, c2, junk, c1};
    endtask

    // Driver: one cycle of stimulus, immediate accept check, expected state queued
    task automatic drive(bit v, int x, bit clr, string tag);
        bit e;
        exp_t it;
        @(negedge clk);
        res_valid = v; res_data = x[11:0]; flag_clr = clr;
        #1;
        e = model_acc(cmp_en, range_en, gt_sel, x, int'(c1), int'(c2));
        check(accept === e, tag, int'(accept), int'(e));
        if (v && e) begin m_data = x[11:0]; m_flag = 1'b1; end
        else if (clr) m_flag = 1'b0;
        it.d = m_data; it.f = m_flag; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compares registered outputs one cycle after each driven item
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(stored_data === e.d, {e.tag, " R10/R11 data"}, int'(stored_data), int'(e.d));
            check(done_flag === e.f, {e.tag, " R12 flag"}, int'(done_flag), int'(e.f));
        end
    end

    function automatic int clampv(int v);
        if (v < 0) return 0;
        if (v > 4095) return 4095;
        return v;
    endfunction

    task automatic sweep(string tag);
        int pts[10];
        pts = '{0, clampv(int'(c1)-1), int'(c1), clampv(int'(c1)+1),
                clampv(int'(c2)-1), int'(c2), clampv(int'(c2)+1), 4095, 2048, 1};
        for (int i = 0; i < 10; i++) drive(1'b1, pts[i], 1'b0, tag);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check(done_flag === 1'b0, "R13 flag", int'(done_flag), 0);
        check(stored_data === 12'd0, "R13 data", int'(stored_data), 0);

        set_cfg(0, 0, 0, 100, 200, 4'h0); sweep("R2 pass");
        set_cfg(1, 0, 0, 1000, 3000, 4'h0); sweep("R3 below");
        set_cfg(1, 0, 1, 1000, 3000, 4'h0); sweep("R4 at_above");
        // R5: second value moved, single-threshold result must not change
        set_cfg(1, 0, 1, 1000, 5, 4'h0); sweep("R5 cv2 ignored");
        set_cfg(1, 0, 0, 1000, 4095, 4'h0); sweep("R5 cv2 ignored lt");
        set_cfg(1, 1, 1, 500, 1500, 4'h0); sweep("R6 in_incl");
        set_cfg(1, 1, 1, 700, 700, 4'h0); sweep("R6 in_incl equal");
        set_cfg(1, 1, 0, 500, 1500, 4'h0); sweep("R7 in_excl");
        set_cfg(1, 1, 0, 700, 700, 4'h0); sweep("R7 in_excl empty");
        set_cfg(1, 1, 1, 3000, 800, 4'h0); sweep("R8 out_incl");
        set_cfg(1, 1, 0, 3000, 800, 4'h0); sweep("R9 out_excl");
        // R1: junk in unused bits must not disturb the fields
        set_cfg(1, 1, 1, 500, 1500, 4'hF); sweep("R1 field pos");
        set_cfg(1, 0, 0, 1000, 0, 4'hA); sweep("R1 field pos lt");

        // R10/R11 explicit: accepted then rejected result
        set_cfg(1, 0, 0, 1000, 0, 4'h0);
        drive(1'b1, 321, 1'b0, "R10 accept store");
        drive(1'b1, 2000, 1'b0, "R11 reject keep");
        drive(1'b0, 5, 1'b0, "R11 idle keep");
        // R12: clear alone, then clear with accepted result
        drive(1'b0, 5, 1'b1, "R12 clear");
        drive(1'b1, 2500, 1'b1, "R12 clear+reject");
        drive(1'b1, 77, 1'b1, "R12 set wins");
        drive(1'b0, 0, 1'b0, "R12 idle");
        drive(1'b0, 0, 1'b0, "tail");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule